// File: doc/BRIEF.md
# Sized Byte Memory with Boot Page Loader

This block is the byte-wide main memory behind a small processor. Only part of the address space counts as populated, and the processor can move that boundary at run time in coarse granules. A read above the boundary returns all ones and a write above it is dropped, as if no memory were fitted there. The populated part starts out cleared. Shrinking the boundary zeroes everything that falls off the top, so bytes that come back into range later read as zero.

The top page of the address space belongs to a boot loader, whose image is a parameter. When the processor fetches an instruction from the first byte of that page, the block first writes the image into RAM, one byte per clock, and only then answers the fetch. From then on the loader runs out of ordinary, writable RAM. Only the first `COPY_LEN` bytes of the image are written. The rest of the page keeps whatever it held before.

With `ADDR_W` = 16 the granule is 4 KB and the loader page starts at 0xFF00. The default build uses `ADDR_W` = 11, which gives 128-byte granules and a page at 0x700, so that the storage stays small.

Top module: `boot_overlay_mem`

## Requirements
- R1: A read at an address at or above the populated limit (size_steps × 2^(ADDR_W−STEPS_LOG2) bytes) returns 8'hFF. A write there leaves memory unchanged.
- R2: `size_steps` is a granule count, valid from 1 to 2^STEPS_LOG2. An invalid count (0 or larger than the maximum) raises `size_reject` in the cycle after the write for exactly one cycle and keeps the previous limit. A valid count raises no reject and takes effect at once.
- R3: A request is taken only in a cycle with `busy` low and `size_wr` low. A taken read gives `rsp_valid` with the data in the next cycle. A write gives no response.
- R4: After reset, `busy` stays high while every byte is cleared to zero, and the limit is `RESET_STEPS` granules. Afterwards every populated byte reads 0.
- R5: A valid size below the current one keeps `busy` high while it zeroes every byte between the new and old limits. Growing the size again then shows those bytes as 0.
- R6: A taken fetch (`req_fetch`=1, `req_write`=0) at BOOT_ADDR = 2^ADDR_W − 256 raises `busy` in the next cycle. It then writes image byte i to BOOT_ADDR+i, one per cycle, for i below COPY_LEN. `busy` stays high for exactly COPY_LEN+1 cycles. The fetch response carries image byte 0 in the first cycle that `busy` is low again.
- R7: The page bytes from BOOT_ADDR+COPY_LEN to the end of the page are not changed by a copy.
- R8: Requests presented while `busy` is high are ignored. A repeated boot fetch does not restart or lengthen the copy, and a write made during the copy does not land.
- R9: A plain data read at BOOT_ADDR, or a fetch at any other address, is an ordinary one-cycle read and starts no copy.
- R10: When the loader page lies above the limit, the copy's writes are dropped and the fetch response is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| busy | output | 1 | Clear or copy in progress, requests ignored |
| size_wr | input | 1 | Load a new populated size |
| size_steps | input | STEPS_LOG2+1 | New size in granules |
| size_reject | output | 1 | One-cycle pulse for an invalid size |

## Verification
A long seeded random mix of reads, writes and size changes is checked against a reference array with its own limit. This covers addresses on both sides of the boundary, so a wrong limit comparison or a missed clear on shrink shows up as a data mismatch. Directed runs start the loader with the page populated, and again with it cut off. The busy length and the untouched page tail separate a wrong copy length from a wrong destination. Repeated fetches and writes injected during a copy tell ignored requests apart from a restarted copy. Sizes of zero and above the maximum check the reject pulse and that the old limit is kept.

// File: rtl/bovl_pkg.sv
package bovl_pkg;

   localparam int BOVL_PAGE_BYTES = 256;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_CLEAR = 2'd1,
      SQ_COPY  = 2'd2,
      SQ_FETCH = 2'd3
   } seq_state_t;

   // Default loader image: a simple computed byte pattern.
   function automatic logic [BOVL_PAGE_BYTES*8-1:0] bovl_default_img();
      logic [BOVL_PAGE_BYTES*8-1:0] v;
      for (int i = 0; i < BOVL_PAGE_BYTES; i++) v[i*8 +: 8] = 8'((i * 37 + 11) & 255);
      return v;
   endfunction

endpackage

// File: rtl/bovl_size_ctl.sv
module bovl_size_ctl #(
   parameter int ADDR_W      = 11,
   parameter int STEPS_LOG2  = 4,
   parameter int RESET_STEPS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [STEPS_LOG2:0] wr_steps,
   output logic [ADDR_W:0]     limit,
   output logic                reject,
   output logic                shrink,
   output logic [ADDR_W:0]     new_limit
);
   localparam int GRAN_W    = ADDR_W - STEPS_LOG2;
   localparam int NUM_STEPS = 1 << STEPS_LOG2;

   logic [STEPS_LOG2:0] steps_q;
   logic                valid;

   assign valid     = (wr_steps != '0) && (int'(wr_steps) <= NUM_STEPS);
   assign limit     = {steps_q, {GRAN_W{1'b0}}};
   assign new_limit = {wr_steps, {GRAN_W{1'b0}}};
   assign shrink    = wr_en && valid && (wr_steps < steps_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         steps_q <= (STEPS_LOG2+1)'(RESET_STEPS);
         reject  <= 1'b0;
      end else begin
         reject <= wr_en && !valid;
         if (wr_en && valid) steps_q <= wr_steps;
      end
   end
endmodule

// File: rtl/bovl_ram.sv
module bovl_ram #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[addr] <= wdata;
      if (re) rdata <= store[addr];
   end
endmodule

// File: rtl/bovl_seq.sv
module bovl_seq
   import bovl_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int COPY_LEN = 250,
   parameter logic [BOVL_PAGE_BYTES*8-1:0] BOOT_IMG = bovl_default_img()
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              req_fetch,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              shrink,
   input  logic [ADDR_W:0]   shrink_lo,
   input  logic [ADDR_W:0]   shrink_hi,
   output logic              busy,
   output logic              trig,
   output logic              eng_we,
   output logic              eng_rd,
   output logic              eng_bypass,
   output logic [ADDR_W-1:0] eng_addr,
   output logic [7:0]        eng_wdata
);
   localparam int MEM_BYTES = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] BOOT_A = ADDR_W'(MEM_BYTES - BOVL_PAGE_BYTES);
   localparam logic [ADDR_W:0]   LAST_CP = (ADDR_W+1)'(COPY_LEN - 1);

   seq_state_t      st;
   logic [ADDR_W:0] ptr, end_q;
   logic [7:0]      pg_idx;

   assign busy   = (st != SQ_IDLE);
   assign trig   = acc && req_fetch && !req_write && (req_addr == BOOT_A);
   assign pg_idx = ptr[7:0];

   always_comb begin
      eng_we     = 1'b0;
      eng_rd     = 1'b0;
      eng_bypass = 1'b0;
      eng_addr   = BOOT_A;
      eng_wdata  = 8'h00;
      case (st)
         SQ_CLEAR: begin
            eng_we     = 1'b1;
            eng_bypass = 1'b1;
            eng_addr   = ptr[ADDR_W-1:0];
         end
         SQ_COPY: begin
            eng_we    = 1'b1;
            eng_addr  = BOOT_A + ADDR_W'(pg_idx);
            eng_wdata = BOOT_IMG[pg_idx*8 +: 8];
         end
         SQ_FETCH: eng_rd = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SQ_CLEAR;
         ptr   <= '0;
         end_q <= (ADDR_W+1)'(MEM_BYTES);
      end else begin
         case (st)
            SQ_IDLE: begin
               if (shrink) begin
                  st    <= SQ_CLEAR;
                  ptr   <= shrink_lo;
                  end_q <= shrink_hi;
               end else if (trig) begin
                  st  <= SQ_COPY;
                  ptr <= '0;
               end
            end
            SQ_CLEAR: begin
               ptr <= ptr + 1'b1;
               if (ptr + 1'b1 == end_q) st <= SQ_IDLE;
            end
            SQ_COPY: begin
               ptr <= ptr + 1'b1;
               if (ptr == LAST_CP) st <= SQ_FETCH;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/boot_overlay_mem.sv
module boot_overlay_mem
   import bovl_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int STEPS_LOG2  = 4,
   parameter int COPY_LEN    = 250,
   parameter int RESET_STEPS = 16,
   parameter logic [BOVL_PAGE_BYTES*8-1:0] BOOT_IMG = bovl_default_img()
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic                req_fetch,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [7:0]          req_wdata,
   output logic                rsp_valid,
   output logic [7:0]          rsp_data,
   output logic                busy,
   input  logic                size_wr,
   input  logic [STEPS_LOG2:0] size_steps,
   output logic                size_reject
);
   localparam int MEM_BYTES = 1 << ADDR_W;
   localparam int NUM_STEPS = 1 << STEPS_LOG2;
   localparam logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'(MEM_BYTES - BOVL_PAGE_BYTES);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must lie in 9..16");
      end
      if (STEPS_LOG2 < 1 || STEPS_LOG2 >= ADDR_W) begin : g_bad_steps
         $error("STEPS_LOG2 must lie in 1..ADDR_W-1");
      end
      if (COPY_LEN < 1 || COPY_LEN > BOVL_PAGE_BYTES) begin : g_bad_copy
         $error("COPY_LEN must lie in 1..page size");
      end
      if (RESET_STEPS < 1 || RESET_STEPS > NUM_STEPS) begin : g_bad_rst
         $error("RESET_STEPS must lie in 1..2**STEPS_LOG2");
      end
   endgenerate

   logic              busy_i, acc, trig;
   logic              eng_we, eng_rd, eng_bypass;
   logic [ADDR_W-1:0] eng_addr;
   logic [7:0]        eng_wdata;
   logic [ADDR_W:0]   lim, new_lim;
   logic              shrink;
   logic              ram_we, rd_en, rng_q;
   logic [ADDR_W-1:0] ram_addr;
   logic [7:0]        ram_wdata, ram_rdata;

   function automatic logic in_rng(input logic [ADDR_W-1:0] a, input logic [ADDR_W:0] l);
      return {1'b0, a} < l;
   endfunction

   assign acc  = req_valid && !busy_i && !size_wr;
   assign busy = busy_i;

   bovl_size_ctl #(
      .ADDR_W(ADDR_W), .STEPS_LOG2(STEPS_LOG2), .RESET_STEPS(RESET_STEPS)
   ) u_size (
      .clk(clk), .rst_n(rst_n), .wr_en(size_wr && !busy_i), .wr_steps(size_steps),
      .limit(lim), .reject(size_reject), .shrink(shrink), .new_limit(new_lim)
   );

   bovl_seq #(
      .ADDR_W(ADDR_W), .COPY_LEN(COPY_LEN), .BOOT_IMG(BOOT_IMG)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .acc(acc), .req_fetch(req_fetch), .req_write(req_write),
      .req_addr(req_addr), .shrink(shrink), .shrink_lo(new_lim), .shrink_hi(lim),
      .busy(busy_i), .trig(trig), .eng_we(eng_we), .eng_rd(eng_rd),
      .eng_bypass(eng_bypass), .eng_addr(eng_addr), .eng_wdata(eng_wdata)
   );

   // Single RAM port shared between the requester and the fill engine.
   assign ram_addr  = busy_i ? eng_addr  : req_addr;
   assign ram_wdata = busy_i ? eng_wdata : req_wdata;
   assign ram_we    = busy_i ? (eng_we && (eng_bypass || in_rng(eng_addr, lim)))
                             : (acc && req_write && in_rng(req_addr, lim));
   assign rd_en     = busy_i ? eng_rd : (acc && !req_write && !trig);

   bovl_ram #(.ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .we(ram_we), .re(rd_en), .addr(ram_addr),
      .wdata(ram_wdata), .rdata(ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rng_q     <= 1'b0;
      end else begin
         rsp_valid <= rd_en;
         if (rd_en) rng_q <= in_rng(ram_addr, lim);
      end
   end

   assign rsp_data = rng_q ? ram_rdata : 8'hFF;
endmodule

// File: rtl/boot_overlay_mem_chk.sv
module boot_overlay_mem_chk #(
   parameter int ADDR_W = 11,
   parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_fetch,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic [7:0]        rsp_data,
   input logic              busy,
   input logic              size_wr,
   input logic              size_reject,
   input logic [ADDR_W:0]   limit
);
   AST_ABSENT_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_valid && !req_write && !busy && !size_wr && ({1'b0, req_addr} >= limit)))
      |-> (rsp_data == 8'hFF)); // R1

   AST_REJECT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      size_reject |-> $past(size_wr && !busy)); // R2

   AST_NO_WRITE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_write && !busy && !size_wr) |-> !rsp_valid); // R3

   AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !busy); // R3

   AST_BOOT_FETCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fetch && !req_write && !busy && !size_wr && (req_addr == BOOT_ADDR))
      |=> (busy && !rsp_valid)); // R6
endmodule

bind boot_overlay_mem boot_overlay_mem_chk #(
   .ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_fetch(req_fetch), .req_addr(req_addr), .rsp_valid(rsp_valid),
   .rsp_data(rsp_data), .busy(busy), .size_wr(size_wr),
   .size_reject(size_reject), .limit(lim)
);

// File: tb/tb_boot_overlay_mem.sv
`timescale 1ns/1ps
module tb_boot_overlay_mem;
   localparam int AW = 11;
   localparam int MEM = 1 << AW;
   localparam int GRAN = 128;
   localparam int MAXS = 16;
   localparam int BOOT = MEM - 256;
   localparam int CLEN = 250;

   function automatic logic [2047:0] tb_img();
      logic [2047:0] v;
      for (int i = 0; i < 256; i++) v[i*8 +: 8] = 8'((i * 91 + 5) ^ (i >> 3));
      return v;
   endfunction
   localparam logic [2047:0] IMG = tb_img();

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0, req_fetch = 0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic rsp_valid, busy, size_reject;
   logic [7:0] rsp_data;
   logic size_wr = 0;
   logic [4:0] size_steps = '0;

   int checks = 0, errors = 0;
   logic [7:0] refm [MEM];
   int ref_steps = MAXS;
   bit done = 0;

   always #4 clk = ~clk;

   boot_overlay_mem #(.ADDR_W(AW), .STEPS_LOG2(4), .COPY_LEN(CLEN), .RESET_STEPS(MAXS),
                      .BOOT_IMG(IMG)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
      .size_wr(size_wr), .size_steps(size_steps), .size_reject(size_reject));

   function automatic logic [7:0] img_b(input int i);
      return IMG[i*8 +: 8];
   endfunction

   function automatic logic [7:0] exp_rd(input int a);
      return (a < ref_steps * GRAN) ? refm[a] : 8'hFF;
   endfunction

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic do_write(input int a, input logic [7:0] d, input string rq);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_fetch = 0; req_addr = AW'(a); req_wdata = d;
      @(negedge clk);
      chk({rq, " write gives no response"}, rsp_valid, 0);
      req_valid = 0; req_write = 0;
      if (a < ref_steps * GRAN) refm[a] = d;
   endtask

   task automatic do_read(input int a, input bit f, input string rq);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_fetch = f; req_addr = AW'(a);
      @(negedge clk);
      chk({rq, " rsp_valid"}, rsp_valid, 1);
      chk({rq, " data"}, rsp_data, exp_rd(a));
      req_valid = 0; req_fetch = 0;
   endtask

   task automatic set_size(input int s, input string rq);
      bit ok;
      ok = (s >= 1) && (s <= MAXS);
      @(negedge clk);
      size_wr = 1; size_steps = 5'(s);
      @(negedge clk);
      size_wr = 0;
      chk({rq, " size_reject"}, size_reject, ok ? 0 : 1);
      @(negedge clk);
      chk({rq, " reject one cycle"}, size_reject, 0);
      if (ok) begin
         if (s < ref_steps)
            for (int i = s * GRAN; i < ref_steps * GRAN; i++) refm[i] = 8'h00;
         ref_steps = s;
      end
      wait_idle();
   endtask

   // Runs a boot fetch; returns busy length; optional injection during copy.
   task automatic boot_fetch(input bit inject, output int cnt, output int data);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_fetch = 1; req_addr = AW'(BOOT);
      @(negedge clk);
      req_valid = 0; req_fetch = 0;
      cnt = 0;
      while (!rsp_valid && cnt < 1000) begin
         if (busy) cnt++;
         if (inject && cnt == 10) begin
            req_valid = 1; req_fetch = 1; req_write = 0; req_addr = AW'(BOOT);
         end else if (inject && cnt == 11) begin
            req_fetch = 0; req_write = 1; req_addr = AW'(5); req_wdata = 8'hAA;
         end else begin
            req_valid = 0; req_write = 0; req_fetch = 0;
         end
         @(negedge clk);
      end
      chk("R6 busy low with fetch response", busy, 0);
      data = rsp_data;
      for (int i = 0; i < CLEN; i++) if (BOOT + i < ref_steps * GRAN) refm[BOOT + i] = img_b(i);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hang expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int cnt, data;
      void'($urandom(32'd1234));
      for (int i = 0; i < MEM; i++) refm[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk("R4 reset rsp_valid", rsp_valid, 0);
      chk("R4 reset size_reject", size_reject, 0);
      chk("R4 busy while clearing", busy, 1);
      rst_n = 1;
      @(negedge clk);
      chk("R4 busy after release", busy, 1);
      wait_idle();
      do_read(0, 0, "R4 zero low");
      do_read(MEM - 1, 0, "R4 zero top");
      do_read(BOOT + 3, 0, "R4 zero page");

      // Boundary and absent memory
      set_size(4, "R5 shrink to 4");
      do_write(4 * GRAN - 1, 8'h5C, "R1 below limit");
      do_read(4 * GRAN - 1, 0, "R1 last populated");
      do_write(4 * GRAN, 8'h77, "R1 absent write");
      do_read(4 * GRAN, 0, "R1 absent read FF");
      set_size(0, "R2 zero size");
      set_size(17, "R2 oversize");
      do_read(4 * GRAN, 0, "R2 limit kept");
      set_size(MAXS, "R2 grow");
      do_read(4 * GRAN, 0, "R1 dropped write stays zero");

      // Shrink clears
      do_write(10 * GRAN + 3, 8'h3E, "R5 seed");
      set_size(9, "R5 shrink to 9");
      set_size(MAXS, "R5 regrow");
      do_read(10 * GRAN + 3, 0, "R5 cleared byte");

      // Boot copy
      for (int i = CLEN; i < 256; i++) do_write(BOOT + i, 8'(8'hC0 + i), "R7 seed tail");
      do_write(5, 8'h11, "R8 seed");
      boot_fetch(1, cnt, data);
      chk("R8 copy length not restarted", cnt, CLEN + 1);
      chk("R6 fetch returns image byte 0", data, img_b(0));
      for (int i = 0; i < 256; i += 17) do_read(BOOT + i, 0, "R6/R7 page content");
      do_read(BOOT + CLEN, 0, "R7 first tail byte");
      do_read(BOOT + 255, 0, "R7 last tail byte");
      do_read(5, 0, "R8 write during copy ignored");
      do_write(BOOT + 1, 8'h99, "R9 patch page");
      do_read(BOOT, 0, "R9 data read at boot address");
      chk("R9 no copy on data read", busy, 0);
      do_read(BOOT + 1, 1, "R9 fetch elsewhere");
      chk("R9 no copy on other fetch", busy, 0);

      // Page above limit
      set_size(8, "R10 shrink below page");
      boot_fetch(0, cnt, data);
      chk("R10 fetch answer absent", data, 8'hFF);
      chk("R10 busy length", cnt, CLEN + 1);
      set_size(MAXS, "R10 regrow");
      do_read(BOOT + 2, 0, "R10 page stays zero");

      // Seeded random mix
      for (int n = 0; n < 3000; n++) begin
         int op, a;
         op = int'($urandom_range(0, 99));
         a  = int'($urandom_range(0, MEM - 1));
         if (a == BOOT) a = 0;
         if (op < 45) do_write(a, 8'($urandom), "R1 random write");
         else if (op < 97) do_read(a, op[0], "R1 random read");
         else set_size(int'($urandom_range(0, 18)), "R2 random size");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule